// File: doc/BRIEF.md
# Crosspoint Switch Control Store

This block keeps the on/off state of every crosspoint in a 12-row by 8-column switch matrix, one bit per crossing and 96 bits in all. A controller presents a row code, a column code and a data bit, then raises a write strobe. The addressed cell takes the data bit while the strobe stays high and keeps the last value it saw once the strobe drops. No other cell moves. An active-high master reset clears every cell at once, without waiting for a clock.

The transparent latches of a classic crosspoint controller are replaced by flip-flops on a fast system clock. Each rising clock edge at which the strobe is high loads the addressed cell from the data bit. The first edge that sees the strobe low leaves the map frozen. An optional input register stage, chosen by a parameter, adds one cycle of latency for a strobe that arrives from another timing domain. The 96-bit output drives the switch enables directly.

Top module: `xpt_ctrl_store`

## Requirements
- R1: Raising `rst` clears all 96 bits of `sw_en` to 0 at once, without a clock edge.
- R2: At a clock edge where `wr_stb` is 1 and the row code is below 12, `sw_en[row*8 + col]` becomes `wr_dat`. A 1 turns that crosspoint on. Bit 0 is row 0 / column 0 and bit 95 is row 11 / column 7.
- R3: Writing 0 to a cell that is on turns it off.
- R4: A write changes at most one bit of `sw_en`, and all other bits keep their values.
- R5: At an edge where `wr_stb` is 0, `sw_en` does not change, whatever the address and data inputs hold.
- R6: While `wr_stb` stays high over several edges, the addressed cell follows `wr_dat` at each edge. After the strobe falls, the cell keeps the value from the last edge at which the strobe was high.
- R7: A strobed write with a row code of 12 to 15 changes no bit of `sw_en`.
- R8: While `rst` is high, `sw_en` stays 0 even when strobed writes of 1 are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobe |
| rst | input | 1 | Asynchronous master clear, active high |
| row_sel | input | 4 | Row code, 0 to 11 valid |
| col_sel | input | 3 | Column code, 0 to 7 |
| wr_dat | input | 1 | Cell value: 1 on, 0 off |
| wr_stb | input | 1 | Write strobe, active high |
| sw_en | output | 96 | Crosspoint enables, bit row*8+col |

## Verification
The bench tries the write path with four kinds of stimulus. A full ascending sweep sets each of the 96 cells in turn. A descending sweep then clears them. Together the two sweeps separate a correct row*8+col mapping from swapped or shifted indices, and catch writes that reach a neighbouring cell. A sweep with the strobe low but varied address and data, and a strobed sweep over row codes 12 to 15, show that idle cycles and unused codes leave the map unchanged. Toggling the data under a held strobe shows that the last strobed value is the one kept. A reset asserted mid-write, checked between clock edges, separates an asynchronous clear from a synchronous one.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   // Flat bit position of a crosspoint in the enable vector.
   function automatic int unsigned xpt_cell_idx(input int unsigned row,
                                                input int unsigned col,
                                                input int unsigned cols);
      return row * cols + col;
   endfunction
endpackage

// File: rtl/xpt_in_stage.sv
module xpt_in_stage #(
   parameter int ROW_AW = 4,
   parameter int COL_AW = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ROW_AW-1:0] row_i,
   input  logic [COL_AW-1:0] col_i,
   input  logic              dat_i,
   input  logic              stb_i,
   output logic [ROW_AW-1:0] row_o,
   output logic [COL_AW-1:0] col_o,
   output logic              dat_o,
   output logic              stb_o
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         row_o <= '0;
         col_o <= '0;
         dat_o <= 1'b0;
         stb_o <= 1'b0;
      end else begin
         row_o <= row_i;
         col_o <= col_i;
         dat_o <= dat_i;
         stb_o <= stb_i;
      end
   end
endmodule

// File: rtl/xpt_addr_dec.sv
module xpt_addr_dec
   import xpt_pkg::*;
#(
   parameter int ROWS   = 12,
   parameter int COLS   = 8,
   parameter int ROW_AW = 4,
   parameter int COL_AW = 3,
   localparam int NCELL = ROWS * COLS
) (
   input  logic              stb,
   input  logic [ROW_AW-1:0] row,
   input  logic [COL_AW-1:0] col,
   output logic [NCELL-1:0]  hit
);
   // One AND term per crossing; codes past ROWS/COLS match no term.
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         assign hit[xpt_cell_idx(r, c, COLS)] =
            stb & (row == ROW_AW'(r)) & (col == COL_AW'(c));
      end
   end
endmodule

// File: rtl/xpt_cell_bank.sv
module xpt_cell_bank #(
   parameter int NCELL = 96
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NCELL-1:0] hit,
   input  logic             dat,
   output logic [NCELL-1:0] q
);
   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      always_ff @(posedge clk or posedge rst) begin
         if (rst)         q[i] <= 1'b0;
         else if (hit[i]) q[i] <= dat;
      end
   end
endmodule

// File: rtl/xpt_ctrl_store.sv
module xpt_ctrl_store #(
   parameter int ROWS   = 12,
   parameter int COLS   = 8,
   parameter int ROW_AW = 4,
   parameter int COL_AW = 3,
   parameter bit IN_REG = 1'b0,
   localparam int NCELL = ROWS * COLS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ROW_AW-1:0] row_sel,
   input  logic [COL_AW-1:0] col_sel,
   input  logic              wr_dat,
   input  logic              wr_stb,
   output logic [NCELL-1:0]  sw_en
);
   if (ROWS < 1 || ROWS > (1 << ROW_AW)) begin : g_bad_rows
      $error("xpt_ctrl_store: ROWS does not fit ROW_AW");
   end
   if (COLS < 1 || COLS > (1 << COL_AW)) begin : g_bad_cols
      $error("xpt_ctrl_store: COLS does not fit COL_AW");
   end

   logic [ROW_AW-1:0] s_row;
   logic [COL_AW-1:0] s_col;
   logic              s_dat;
   logic              s_stb;
   logic [NCELL-1:0]  hit;

   if (IN_REG) begin : g_in_reg
      xpt_in_stage #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_in (
         .clk(clk), .rst(rst),
         .row_i(row_sel), .col_i(col_sel), .dat_i(wr_dat), .stb_i(wr_stb),
         .row_o(s_row), .col_o(s_col), .dat_o(s_dat), .stb_o(s_stb));
   end else begin : g_in_direct
      assign s_row = row_sel;
      assign s_col = col_sel;
      assign s_dat = wr_dat;
      assign s_stb = wr_stb;
   end

   xpt_addr_dec #(.ROWS(ROWS), .COLS(COLS), .ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_dec (
      .stb(s_stb), .row(s_row), .col(s_col), .hit(hit));

   xpt_cell_bank #(.NCELL(NCELL)) u_bank (
      .clk(clk), .rst(rst), .hit(hit), .dat(s_dat), .q(sw_en));
endmodule

// File: rtl/xpt_ctrl_store_chk.sv
module xpt_ctrl_store_chk #(
   parameter int ROWS   = 12,
   parameter int COLS   = 8,
   parameter int ROW_AW = 4,
   parameter int COL_AW = 3,
   localparam int NCELL = ROWS * COLS,
   localparam int IW    = ROW_AW + COL_AW + 1
) (
   input logic              clk,
   input logic              rst,
   input logic [ROW_AW-1:0] s_row,
   input logic [COL_AW-1:0] s_col,
   input logic              s_dat,
   input logic              s_stb,
   input logic [NCELL-1:0]  sw_en
);
   logic          in_range;
   logic [IW-1:0] idx;
   assign in_range = (int'(s_row) < ROWS) && (int'(s_col) < COLS);
   assign idx      = IW'(s_row) * IW'(COLS) + IW'(s_col);

   p_reset_clear_r1: assert property (@(posedge clk) rst |-> (sw_en == '0));

   p_write_follow_r2: assert property (@(posedge clk) disable iff (rst)
      (s_stb && in_range) |=> (sw_en[$past(idx)] == $past(s_dat)));

   p_single_cell_r4: assert property (@(posedge clk) disable iff (rst)
      s_stb |=> ($countones(sw_en ^ $past(sw_en)) <= 1));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !s_stb |=> $stable(sw_en));

   p_unused_row_r7: assert property (@(posedge clk) disable iff (rst)
      (s_stb && !in_range) |=> $stable(sw_en));
endmodule

bind xpt_ctrl_store xpt_ctrl_store_chk #(
   .ROWS(ROWS), .COLS(COLS), .ROW_AW(ROW_AW), .COL_AW(COL_AW)
) u_chk (
   .clk(clk), .rst(rst), .s_row(s_row), .s_col(s_col),
   .s_dat(s_dat), .s_stb(s_stb), .sw_en(sw_en));

// File: tb/xpt_ctrl_store_bench.sv
module xpt_ctrl_store_bench;
   localparam int ROWS = 12;
   localparam int COLS = 8;
   localparam int N    = ROWS * COLS;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [3:0]   row_sel = '0;
   logic [2:0]   col_sel = '0;
   logic         wr_dat = 1'b0;
   logic         wr_stb = 1'b0;
   logic [N-1:0] sw_en;
   logic [N-1:0] model = '0;
   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   xpt_ctrl_store u_xpt_ctrl_store (
      .clk(clk), .rst(rst), .row_sel(row_sel), .col_sel(col_sel),
      .wr_dat(wr_dat), .wr_stb(wr_stb), .sw_en(sw_en));

   task automatic compare(input string req, input logic [N-1:0] exp);
      checks++;
      if (sw_en !== exp) begin
         fails++;
         $display("FAIL %s: sw_en=%h expected %h", req, sw_en, exp);
      end
   endtask

   // Drive one cycle of inputs, let one rising edge pass, then check.
   task automatic step(input string req, input logic stb, input int row,
                       input int col, input logic dat);
      wr_stb  = stb;
      row_sel = 4'(row);
      col_sel = 3'(col);
      wr_dat  = dat;
      @(posedge clk);
      #1;
      if (stb && row < ROWS && !rst) model[row*COLS + col] = dat;
      if (rst) model = '0;
      compare(req, model);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare("R1 reset state", '0);
      rst = 1'b0;

      // R2/R4: ascending set sweep, index row*8+col
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            step("R2 R4 set sweep", 1'b1, r, c, 1'b1);
      compare("R2 all on", {N{1'b1}});

      // R3: descending clear sweep
      for (int i = N - 1; i >= 0; i--)
         step("R3 R4 clear sweep", 1'b1, i / COLS, i % COLS, 1'b0);

      // checkerboard pattern
      for (int i = 0; i < N; i++)
         step("R2 checkerboard", 1'b1, i / COLS, i % COLS, 1'((i / COLS + i) & 1));

      // R5: strobe low with varied address and data
      for (int i = 0; i < 64; i++)
         step("R5 idle hold", 1'b0, i % 16, (i * 3) % 8, 1'(i & 1));

      // R7: unused row codes
      for (int r = ROWS; r < 16; r++)
         for (int c = 0; c < COLS; c++) begin
            step("R7 unused row set", 1'b1, r, c, 1'b1);
            step("R7 unused row clr", 1'b1, r, c, 1'b0);
         end

      // R6: data toggling under a held strobe
      step("R6 toggle 1", 1'b1, 7, 2, 1'b1);
      step("R6 toggle 0", 1'b1, 7, 2, 1'b0);
      step("R6 toggle 1b", 1'b1, 7, 2, 1'b1);
      step("R6 retained", 1'b0, 7, 2, 1'b0);
      compare("R6 bit 58 on", model);
      step("R6 toggle end 0", 1'b1, 11, 7, 1'b1);
      step("R6 toggle end 0b", 1'b1, 11, 7, 1'b0);
      step("R6 retained off", 1'b0, 11, 7, 1'b1);

      // R1/R8: reset during a write in progress
      step("R8 write before reset", 1'b1, 3, 5, 1'b1);
      rst = 1'b1;
      #1;
      model = '0;
      compare("R1 async clear", '0);
      step("R8 write under reset", 1'b1, 3, 5, 1'b1);
      step("R8 write under reset b", 1'b1, 0, 0, 1'b1);
      wr_stb = 1'b0;
      #1;
      rst = 1'b0;
      step("R8 after release", 1'b0, 3, 5, 1'b1);
      step("R2 write after reset", 1'b1, 0, 0, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule